// File: doc/BRIEF.md
# Multi-Layout Video Output Formatter

This block takes a stream of full-resolution pixels, one per transfer, each made of three components (luma and two chroma samples, or three colour primaries). Each pixel carries a line-active qualifier and a vertical-blanking qualifier. The block turns that stream into one of three output layouts:

- **Full 4:4:4**: three parallel components.
- **Semi-planar 4:2:2**: luma plus interleaved chroma.
- **Multiplexed 4:2:2**: a single word stream carrying chroma and luma in turn, with optional embedded start and end of active video codes.

Chroma is halved horizontally by a selectable decimation filter. Blanking intervals carry programmable per-channel codes. A per-port selector routes any internal component stream to any output port, or releases the port.

Both data edges are valid/ready streams. An input pixel transfers when `in_valid` and `in_ready` are both high at a rising clock edge. While `in_valid` is high, the pixel fields must stay stable. An output word transfers when `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the output word is held unchanged.

Several conditions stall the input:
- `in_ready` drops while the block is still producing words for an earlier pixel.
- `in_ready` drops while the block is inserting a timing code.
- `in_ready` drops while the output holds an untaken word.

The configuration inputs are static: change them only while the block is idle and the output is empty.

Top module: `yuv_out_fmt`

## Requirements
- R1: With format 0 (and the reserved format 3), every input pixel yields exactly one output word. An active pixel carries component 0, 1 and 2 on internal streams 0, 1 and 2.
- R2: With format 1, two active pixels yield two words: (luma0, Cb) and then (luma1, Cr), with luma on stream 0 and chroma on stream 1. Pairing restarts with Cb at the first active pixel of each line.
- R3: With format 2, each pair of active pixels yields four words on stream 0, in the order Cb, luma0, Cr, luma1. Each input pixel thus produces two output words.
- R4: The filter select chooses how chroma is decimated in formats 1 and 2. At 0, the even pixel's chroma is kept and the odd pixel's chroma is dropped. At 1, the result is (even + odd + 1) >> 1.
- R5: A pixel is blanking when its line-active input is low or its vertical-blanking input is high. In format 0 a blanking pixel outputs the three blanking codes (luma, Cb, Cr). In formats 1 and 2 a blanking pixel outputs the luma code, and its chroma word alternates between the Cb code and the Cr code, starting with the Cb code after any active pixel. In format 2 the chroma word comes first.
- R6: In format 2 with timing codes enabled, a pixel whose line-active value differs from that of the previous accepted pixel is preceded by four stream-0 words: all ones, zero, zero, then the code byte. The code byte has these bits:
  - bit 7 = 1
  - bit 6 = field
  - bit 5 = vertical blanking
  - bit 4 = H, which is 1 when the line-active input went low
  - bit 3 = V^H
  - bit 2 = F^H
  - bit 1 = F^V
  - bit 0 = F^V^H
- R7: In format 2 with timing codes disabled, no code words are inserted, and the blanking interval carries only blanking codes.
- R8: Each port has a 2-bit selector at bits [2p+1:2p]. Values 0, 1 and 2 route that internal stream to the port with its enable high. Value 3 drives the port's data to zero with its enable low.
- R9: In formats 1 and 2, an active pixel left without a partner when a line ends produces no output words.
- R10: The output word stays stable while it is stalled. No word is lost or duplicated under back-pressure, and no word appears without input to cause it.
- R11: During reset and after reset with no input, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_format | input | 2 | 0: 4:4:4, 1: semi-planar, 2: multiplexed, 3: reserved (acts as 0) |
| cfg_avg_filter | input | 1 | Chroma filter: 0 drops odd samples, 1 averages pairs |
| cfg_trc_en | input | 1 | Enable timing-code insertion in format 2 |
| cfg_blank_y | input | W | Blanking code for luma / component 0 |
| cfg_blank_cb | input | W | Blanking code for Cb / component 1 |
| cfg_blank_cr | input | W | Blanking code for Cr / component 2 |
| cfg_port_sel | input | 2*NPORT | Per-port stream selector |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_c0 | input | W | Component 0 (luma) |
| in_c1 | input | W | Component 1 (Cb) |
| in_c2 | input | W | Component 2 (Cr) |
| in_href | input | 1 | Line-active qualifier |
| in_vref | input | 1 | Vertical-blanking qualifier |
| in_field | input | 1 | Field identifier for timing codes |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_port_data | output | NPORT*W | Port data, port p at bits [p*W+W-1:p*W] |
| out_port_oe | output | NPORT | Port drive enable |

## Verification
A corrupted pairing phase would swap Cb and Cr, or shift luma by one pixel. That error shows at the ports on the very next active pair, and the scoreboard catches it at the first mismatched word.

A stale record of the previous line-active value would insert or omit a four-word code group. That shifts every later word, so the fault surfaces within one pixel of the line edge.

A wrong blanking-phase register changes the chroma blanking code on the next blanking pixel. Random back-pressure exercises the hold behaviour, and a dropped or repeated word appears as an order mismatch at once.

// File: rtl/yof_pkg.sv
package yof_pkg;

  typedef enum logic [1:0] {
    FMT_444  = 2'd0,
    FMT_SEMI = 2'd1,
    FMT_MUX  = 2'd2,
    FMT_RSV  = 2'd3
  } fmt_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_CODE = 2'd1,
    SQ_BODY = 2'd2
  } seq_e;

  localparam logic [1:0] PORT_OFF = 2'd3;
  localparam int NSTREAM = 3;

  function automatic logic [7:0] xy_byte(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

endpackage

// File: rtl/yof_chroma_decim.sv
module yof_chroma_decim #(
  parameter int W = 8
) (
  input  logic         avg_en,
  input  logic [W-1:0] cb_even,
  input  logic [W-1:0] cb_odd,
  input  logic [W-1:0] cr_even,
  input  logic [W-1:0] cr_odd,
  output logic [W-1:0] cb_out,
  output logic [W-1:0] cr_out
);
  logic [1:0][W-1:0] ev, od, res;

  assign ev = {cr_even, cb_even};
  assign od = {cr_odd, cb_odd};

  for (genvar g = 0; g < 2; g++) begin : g_ch
    logic [W:0] sum;
    assign sum    = {1'b0, ev[g]} + {1'b0, od[g]} + {{W{1'b0}}, 1'b1};
    assign res[g] = avg_en ? sum[W:1] : ev[g];

    always_comb begin
      if (avg_en) begin
        a_r4_avg_between: assert ((res[g] >= ev[g] || res[g] >= od[g]) &&
                                  (res[g] <= ev[g] || res[g] <= od[g]))
          else $error("R4 average outside input range");
      end
    end
  end

  assign cb_out = res[0];
  assign cr_out = res[1];
endmodule

// File: rtl/yof_trc_word.sv
module yof_trc_word #(
  parameter int W = 8
) (
  input  logic         fld,
  input  logic         vblk,
  input  logic         hend,
  input  logic [1:0]   idx,
  output logic [W-1:0] word
);
  import yof_pkg::*;

  logic [W-1:0] xyw;

  always_comb begin
    xyw = '0;
    xyw[W-1 -: 8] = xy_byte(fld, vblk, hend);
    case (idx)
      2'd0:    word = '1;
      2'd3:    word = xyw;
      default: word = '0;
    endcase
  end
endmodule

// File: rtl/yof_port_map.sv
module yof_port_map #(
  parameter int W     = 8,
  parameter int NPORT = 3
) (
  input  logic [yof_pkg::NSTREAM-1:0][W-1:0] streams,
  input  logic [2*NPORT-1:0]                 sel,
  output logic [NPORT*W-1:0]                 data,
  output logic [NPORT-1:0]                   oe
);
  import yof_pkg::*;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [1:0] s;
    assign s = sel[2*p +: 2];
    always_comb begin
      if (s == PORT_OFF) begin
        data[p*W +: W] = '0;
        oe[p]          = 1'b0;
      end else begin
        data[p*W +: W] = streams[s];
        oe[p]          = 1'b1;
      end
    end
  end
endmodule

// File: rtl/yuv_out_fmt.sv
module yuv_out_fmt #(
  parameter int W     = 8,
  parameter int NPORT = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         cfg_format,
  input  logic               cfg_avg_filter,
  input  logic               cfg_trc_en,
  input  logic [W-1:0]       cfg_blank_y,
  input  logic [W-1:0]       cfg_blank_cb,
  input  logic [W-1:0]       cfg_blank_cr,
  input  logic [2*NPORT-1:0] cfg_port_sel,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [W-1:0]       in_c0,
  input  logic [W-1:0]       in_c1,
  input  logic [W-1:0]       in_c2,
  input  logic               in_href,
  input  logic               in_vref,
  input  logic               in_field,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [NPORT*W-1:0] out_port_data,
  output logic [NPORT-1:0]   out_port_oe
);
  import yof_pkg::*;

  localparam int NBW = 3;

  fmt_e fmt;
  seq_e st_q;
  logic [1:0] k_q;
  logic       last_h_q, pair_ph_q, blank_ph_q, code_last_q, ov_q;
  logic [W-1:0] held0_q, held1_q, held2_q;
  logic [W-1:0] lat0_q, lat1_q, lat2_q;
  logic         lat_act_q, lat_bph_q;
  logic [NBW-1:0] lat_nb_q;
  logic [W-1:0] r_s0, r_s1, r_s2;

  logic slot_free, in_act, is422, code_need, accept;
  logic emit_code, emit_body;
  logic [1:0] k_eff, code_idx;
  logic [W-1:0] src0, src1, src2, dec_cb, dec_cr, code_word;
  logic src_act, src_bph;
  logic [W-1:0] b_s0, b_s1, b_s2;
  logic [NBW-1:0] nbeat_in;

  assign fmt       = fmt_e'(cfg_format);
  assign is422     = (fmt == FMT_SEMI) || (fmt == FMT_MUX);
  assign slot_free = !ov_q || out_ready;
  assign in_act    = in_href && !in_vref;
  assign code_need = (fmt == FMT_MUX) && cfg_trc_en && in_valid && (in_href != last_h_q);
  assign in_ready  = (st_q == SQ_IDLE) && slot_free && !code_need;
  assign accept    = in_valid && in_ready;

  // source pixel: live input while idle, latched copy while emitting extra words
  always_comb begin
    if (st_q == SQ_BODY) begin
      src0 = lat0_q; src1 = lat1_q; src2 = lat2_q;
      src_act = lat_act_q; src_bph = lat_bph_q; k_eff = k_q;
    end else begin
      src0 = in_c0; src1 = in_c1; src2 = in_c2;
      src_act = in_act; src_bph = blank_ph_q; k_eff = 2'd0;
    end
  end

  always_comb begin
    case (fmt)
      FMT_SEMI: nbeat_in = !in_act ? NBW'(1) : (pair_ph_q ? NBW'(2) : NBW'(0));
      FMT_MUX:  nbeat_in = !in_act ? NBW'(2) : (pair_ph_q ? NBW'(4) : NBW'(0));
      default:  nbeat_in = NBW'(1);
    endcase
  end

  yof_chroma_decim #(.W(W)) u_decim (
    .avg_en (cfg_avg_filter),
    .cb_even(held1_q), .cb_odd(src1),
    .cr_even(held2_q), .cr_odd(src2),
    .cb_out (dec_cb),  .cr_out(dec_cr)
  );

  assign code_idx = (st_q == SQ_CODE) ? k_q : 2'd0;

  yof_trc_word #(.W(W)) u_trc (
    .fld (in_field),
    .vblk(in_vref),
    .hend(!in_href),
    .idx (code_idx),
    .word(code_word)
  );

  // word content for the current body beat
  always_comb begin
    b_s0 = '0; b_s1 = '0; b_s2 = '0;
    case (fmt)
      FMT_SEMI: begin
        if (!src_act) begin
          b_s0 = cfg_blank_y;
          b_s1 = src_bph ? cfg_blank_cr : cfg_blank_cb;
        end else if (k_eff == 2'd0) begin
          b_s0 = held0_q; b_s1 = dec_cb;
        end else begin
          b_s0 = src0;    b_s1 = dec_cr;
        end
      end
      FMT_MUX: begin
        if (!src_act) begin
          b_s0 = (k_eff == 2'd0) ? (src_bph ? cfg_blank_cr : cfg_blank_cb) : cfg_blank_y;
        end else begin
          case (k_eff)
            2'd0:    b_s0 = dec_cb;
            2'd1:    b_s0 = held0_q;
            2'd2:    b_s0 = dec_cr;
            default: b_s0 = src0;
          endcase
        end
      end
      default: begin
        if (src_act) begin
          b_s0 = src0; b_s1 = src1; b_s2 = src2;
        end else begin
          b_s0 = cfg_blank_y; b_s1 = cfg_blank_cb; b_s2 = cfg_blank_cr;
        end
      end
    endcase
  end

  assign emit_code = slot_free && ((st_q == SQ_IDLE && code_need) || st_q == SQ_CODE);
  assign emit_body = slot_free && ((st_q == SQ_IDLE && accept && nbeat_in != '0) ||
                                   st_q == SQ_BODY);

  // output register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ov_q <= 1'b0; code_last_q <= 1'b0;
      r_s0 <= '0; r_s1 <= '0; r_s2 <= '0;
    end else if (emit_code) begin
      ov_q <= 1'b1; code_last_q <= (code_idx == 2'd3);
      r_s0 <= code_word; r_s1 <= '0; r_s2 <= '0;
    end else if (emit_body) begin
      ov_q <= 1'b1; code_last_q <= 1'b0;
      r_s0 <= b_s0; r_s1 <= b_s1; r_s2 <= b_s2;
    end else if (out_ready) begin
      ov_q <= 1'b0; code_last_q <= 1'b0;
    end
  end

  // sequencer and line state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= SQ_IDLE; k_q <= 2'd0; last_h_q <= 1'b0;
      pair_ph_q <= 1'b0; blank_ph_q <= 1'b0;
      held0_q <= '0; held1_q <= '0; held2_q <= '0;
      lat0_q <= '0; lat1_q <= '0; lat2_q <= '0;
      lat_act_q <= 1'b0; lat_bph_q <= 1'b0; lat_nb_q <= '0;
    end else begin
      case (st_q)
        SQ_IDLE: begin
          if (emit_code) begin
            st_q <= SQ_CODE; k_q <= 2'd1;
          end else if (accept) begin
            last_h_q <= in_href;
            if (is422) begin
              if (!in_act) begin
                pair_ph_q <= 1'b0; blank_ph_q <= !blank_ph_q;
              end else begin
                blank_ph_q <= 1'b0;
                if (!pair_ph_q) begin
                  held0_q <= in_c0; held1_q <= in_c1; held2_q <= in_c2;
                  pair_ph_q <= 1'b1;
                end else begin
                  pair_ph_q <= 1'b0;
                end
              end
            end else begin
              pair_ph_q <= 1'b0; blank_ph_q <= 1'b0;
            end
            if (nbeat_in > NBW'(1)) begin
              st_q <= SQ_BODY; k_q <= 2'd1; lat_nb_q <= nbeat_in;
              lat0_q <= in_c0; lat1_q <= in_c1; lat2_q <= in_c2;
              lat_act_q <= in_act; lat_bph_q <= blank_ph_q;
            end
          end
        end
        SQ_CODE: begin
          if (slot_free) begin
            if (k_q == 2'd3) begin
              st_q <= SQ_IDLE; last_h_q <= in_href;
            end
            k_q <= k_q + 2'd1;
          end
        end
        SQ_BODY: begin
          if (slot_free) begin
            if ({1'b0, k_q} == lat_nb_q - NBW'(1)) st_q <= SQ_IDLE;
            k_q <= k_q + 2'd1;
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  yof_port_map #(.W(W), .NPORT(NPORT)) u_map (
    .streams({r_s2, r_s1, r_s0}),
    .sel    (cfg_port_sel),
    .data   (out_port_data),
    .oe     (out_port_oe)
  );

  assign out_valid = ov_q;

  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(r_s0) && $stable(r_s1) && $stable(r_s2)))
    else $error("R10 stalled word changed");

  a_r6_code_only_mux: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_CODE) |-> (fmt == FMT_MUX && cfg_trc_en))
    else $error("R6 code insertion outside multiplexed mode");

  a_r6_xy_marker: assert property (@(posedge clk) disable iff (!rst_n)
    code_last_q |-> (out_valid && r_s0[W-1]))
    else $error("R6 code byte lacks marker bit");

  a_r1_single_word: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt == FMT_444) |-> (st_q != SQ_BODY))
    else $error("R1 multi-word burst in 4:4:4 mode");

  a_r9_pair_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !in_act) |=> !pair_ph_q)
    else $error("R9 pairing survived blanking");

endmodule

// File: tb/yuv_out_fmt_bench.sv
module yuv_out_fmt_bench;
  localparam int W = 8;
  localparam int NP = 3;
  localparam logic [5:0] SEL_ID = {2'd2, 2'd1, 2'd0};

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic [1:0] cfg_format = 2'd0;
  logic cfg_avg_filter = 1'b0, cfg_trc_en = 1'b0;
  logic [W-1:0] cfg_blank_y = 8'h10, cfg_blank_cb = 8'h80, cfg_blank_cr = 8'h81;
  logic [2*NP-1:0] cfg_port_sel = SEL_ID;
  logic in_valid = 1'b0, in_ready;
  logic [W-1:0] in_c0 = '0, in_c1 = '0, in_c2 = '0;
  logic in_href = 1'b0, in_vref = 1'b0, in_field = 1'b0;
  logic out_valid, out_ready = 1'b1;
  logic [NP*W-1:0] out_port_data;
  logic [NP-1:0] out_port_oe;

  yuv_out_fmt #(.W(W), .NPORT(NP)) u_yuv_out_fmt (
    .clk(clk), .rst_n(rst_n), .cfg_format(cfg_format), .cfg_avg_filter(cfg_avg_filter),
    .cfg_trc_en(cfg_trc_en), .cfg_blank_y(cfg_blank_y), .cfg_blank_cb(cfg_blank_cb),
    .cfg_blank_cr(cfg_blank_cr), .cfg_port_sel(cfg_port_sel), .in_valid(in_valid),
    .in_ready(in_ready), .in_c0(in_c0), .in_c1(in_c1), .in_c2(in_c2), .in_href(in_href),
    .in_vref(in_vref), .in_field(in_field), .out_valid(out_valid), .out_ready(out_ready),
    .out_port_data(out_port_data), .out_port_oe(out_port_oe)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0, rdy_rand = 0;
  logic [7:0] lfsr = 8'hA5;
  logic [26:0] exp_q[$];
  string tag_q[$];

  // bench reference state
  logic m_last_h = 0, m_ph = 0, m_bph = 0;
  logic [7:0] m_h0 = 0, m_h1 = 0, m_h2 = 0;

  task automatic check(input bit ok, input string tag, input logic [26:0] act, input logic [26:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] xyb(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  function automatic logic [7:0] half(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] t;
    t = {1'b0, a} + {1'b0, b} + 9'd1;
    return cfg_avg_filter ? t[8:1] : a;
  endfunction

  task automatic push3(input logic [7:0] s0, input logic [7:0] s1, input logic [7:0] s2, input string tag);
    logic [7:0] s [3];
    logic [26:0] e;
    logic [1:0] sl;
    string t;
    s[0] = s0; s[1] = s1; s[2] = s2;
    e = '0; t = tag;
    for (int p = 0; p < NP; p++) begin
      sl = cfg_port_sel[2*p +: 2];
      if (sl != 2'd3) begin
        e[8*p +: 8] = s[sl];
        e[24+p] = 1'b1;
      end
    end
    if (cfg_port_sel != SEL_ID) t = "R8";
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic send(input logic [7:0] c0, input logic [7:0] c1, input logic [7:0] c2,
                      input logic h, input logic v, input logic f);
    logic act;
    string bt;
    act = h && !v;
    if (cfg_format == 2'd2 && cfg_trc_en && h != m_last_h) begin
      push3(8'hFF, 8'h00, 8'h00, "R6");
      push3(8'h00, 8'h00, 8'h00, "R6");
      push3(8'h00, 8'h00, 8'h00, "R6");
      push3(xyb(f, v, !h), 8'h00, 8'h00, "R6");
    end
    m_last_h = h;
    if (cfg_format == 2'd1 || cfg_format == 2'd2) begin
      if (!act) begin
        bt = m_ph ? "R9" : "R5";
        if (cfg_format == 2'd2 && !cfg_trc_en) bt = "R7";
        if (cfg_format == 2'd1)
          push3(cfg_blank_y, m_bph ? cfg_blank_cr : cfg_blank_cb, 8'h00, bt);
        else begin
          push3(m_bph ? cfg_blank_cr : cfg_blank_cb, 8'h00, 8'h00, bt);
          push3(cfg_blank_y, 8'h00, 8'h00, bt);
        end
        m_ph = 0;
        m_bph = !m_bph;
      end else begin
        m_bph = 0;
        if (!m_ph) begin
          m_h0 = c0; m_h1 = c1; m_h2 = c2; m_ph = 1;
        end else begin
          if (cfg_format == 2'd1) begin
            push3(m_h0, half(m_h1, c1), 8'h00, "R2");
            push3(c0, half(m_h2, c2), 8'h00, "R4");
          end else begin
            push3(half(m_h1, c1), 8'h00, 8'h00, "R4");
            push3(m_h0, 8'h00, 8'h00, "R3");
            push3(half(m_h2, c2), 8'h00, 8'h00, "R4");
            push3(c0, 8'h00, 8'h00, "R3");
          end
          m_ph = 0;
        end
      end
    end else begin
      m_ph = 0; m_bph = 0;
      if (act) push3(c0, c1, c2, "R1");
      else push3(cfg_blank_y, cfg_blank_cb, cfg_blank_cr, "R5");
    end
    @(negedge clk);
    in_c0 = c0; in_c1 = c1; in_c2 = c2; in_href = h; in_vref = v; in_field = f;
    in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
  endtask

  task automatic line(input int pre, input int act, input int post, input logic v,
                      input logic f, input logic [7:0] base);
    for (int i = 0; i < pre; i++) send(base + 8'(i), base, base, 1'b0, v, f);
    for (int i = 0; i < act; i++)
      send(base + 8'(i * 7), base + 8'(i * 13 + 3), base + 8'(i * 29 + 6), 1'b1, v, f);
    for (int i = 0; i < post; i++) send(base + 8'(i + 9), base, base, 1'b0, v, f);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    #2;
    check(!out_valid, "R10", {26'd0, out_valid}, 27'd0);
  endtask

  // monitor: ready pattern, stall stability and scoreboard compare
  logic stall_prev = 0;
  logic [26:0] stall_val = '0;
  always begin
    logic [26:0] got, e;
    string t;
    @(negedge clk);
    out_ready = rdy_rand ? (lfsr[0] | lfsr[3]) : 1'b1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    #1;
    if (rst_n) begin
      got = {out_port_oe, out_port_data};
      if (stall_prev && out_valid) check(got == stall_val, "R10", got, stall_val);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check(1'b0, "R10", got, 27'd0);
        else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(got == e, t, got, e);
        end
      end
      stall_prev = out_valid && !out_ready;
      stall_val = got;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired (R10) actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!out_valid, "R11", {26'd0, out_valid}, 27'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!out_valid, "R11", {26'd0, out_valid}, 27'd0);

    // R1 full layout, identity routing, then reserved format
    line(2, 4, 2, 1'b0, 1'b0, 8'h20);
    line(1, 2, 0, 1'b1, 1'b0, 8'h30);
    drain();
    cfg_format = 2'd3;
    line(1, 3, 1, 1'b0, 1'b0, 8'h44);
    drain();

    // R2 semi-planar, drop filter, back-pressure on
    rdy_rand = 1;
    cfg_format = 2'd1; cfg_avg_filter = 1'b0;
    line(2, 6, 2, 1'b0, 1'b0, 8'h51);
    drain();
    // R4 averaging plus R9 odd active count
    cfg_avg_filter = 1'b1;
    line(2, 5, 3, 1'b0, 1'b0, 8'h63);
    drain();

    // R3 and R6 multiplexed with timing codes
    cfg_format = 2'd2; cfg_trc_en = 1'b1;
    line(3, 4, 3, 1'b0, 1'b1, 8'h75);
    line(2, 3, 2, 1'b1, 1'b0, 8'h87);
    drain();
    cfg_avg_filter = 1'b0;
    line(1, 6, 1, 1'b0, 1'b0, 8'h99);
    drain();

    // R7 codes disabled
    cfg_trc_en = 1'b0;
    line(2, 5, 2, 1'b0, 1'b0, 8'hA1);
    drain();

    // R8 routing with a released port
    cfg_format = 2'd0;
    cfg_port_sel = {2'd1, 2'd0, 2'd3};
    line(1, 3, 1, 1'b0, 1'b0, 8'hB3);
    drain();
    cfg_format = 2'd2; cfg_trc_en = 1'b1;
    cfg_port_sel = {2'd0, 2'd3, 2'd3};
    line(2, 4, 2, 1'b0, 1'b1, 8'hC5);
    drain();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule